// File: doc/BRIEF.md
# Auxiliary-Memory Block DMA Controller

This block copies a block of data between main memory and an auxiliary memory without the host touching each word. The host sets up three 32-bit values through a 16-bit register port, each seen as a high and a low halfword: a main-memory byte address, an auxiliary-memory byte address and a transfer count. Bit 31 of the count picks the direction. Bits 30:0 give the length in bytes.

Writing the low half of the count starts the copy. The engine moves the data in 32-byte bursts, one word at a time. Each word is read from the source memory and then written to the destination memory at the same offset. Both memories use a simple request/acknowledge word port. While the copy runs, a busy bit is set in a separate control/status word. When the last burst finishes, busy clears and an interrupt-pending flag sets. The flag drives the `irq` output until the host clears it.

Top module: `aux_blk_dma`

## Requirements
- R1: After reset the engine is idle. `irq` is 0, the control/status word reads 0, and all six address and count halves read 0.
- R2: Register map by halfword index:
  - 0 = main address high, 1 = main address low.
  - 2 = auxiliary address high, 3 = auxiliary address low.
  - 4 = count high, 5 = count low.
  - 6 = control/status: bit 0 is busy (read-only), bit 1 is pending.
  - Written halves read back unchanged while idle.
- R3: A write to index 5 while idle starts a transfer if the burst count (count bits 30:5) is non-zero. Busy then reads 1 from the next cycle. A write to index 4 alone never starts a transfer.
- R4: Count bits 4:0 are stored but take no part in the burst count. A transfer moves exactly (bits 30:5) bursts of 32 bytes. With 32-bit words that is 8 word copies per burst, at consecutive word addresses.
- R5: When count bit 31 is 0, the engine reads main memory (`mm_we`=0) and writes auxiliary memory (`ax_we`=1). When it is 1, the roles are swapped.
- R6: Busy clears and pending sets in the same cycle, when the final burst's last write is acknowledged. `irq` equals pending.
- R7: After each burst both addresses advance by 32 and the count's length field drops by 32. At the end each address equals its start plus 32 times the burst count, the length holds only its original bits 4:0, and bit 31 is unchanged.
- R8: Writes to indices 0 to 5 while busy change nothing and start nothing.
- R9: A write to index 6 with bit 1 set clears pending. With bit 1 clear, pending is left as it was. No write to index 6 changes busy.
- R10: A count whose bits 30:5 are zero is stored, but busy stays 0 and pending is unchanged.
- R11: Only one memory port requests at a time. A request holds its address, write enable and data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host halfword write strobe |
| h_idx | input | 3 | Host register index |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data for `h_idx` (combinational) |
| irq | output | 1 | Completion interrupt (pending flag) |
| mm_req | output | 1 | Main memory request |
| mm_we | output | 1 | Main memory write enable |
| mm_addr | output | 32 | Main memory byte address |
| mm_wdata | output | DATA_W | Main memory write data |
| mm_ack | input | 1 | Main memory acknowledge |
| mm_rdata | input | DATA_W | Main memory read data, valid with ack |
| ax_req | output | 1 | Auxiliary memory request |
| ax_we | output | 1 | Auxiliary memory write enable |
| ax_addr | output | 32 | Auxiliary memory byte address |
| ax_wdata | output | DATA_W | Auxiliary memory write data |
| ax_ack | input | 1 | Auxiliary memory acknowledge |
| ax_rdata | input | DATA_W | Auxiliary memory read data, valid with ack |

## Verification
The bench builds the block with its defaults, DATA_W = 32 and BURST_BYTES = 32. This gives eight word copies per burst, so the last-word-of-burst wrap and the burst-to-burst address step are both reached within short transfers. The memory model acknowledges after one to three cycles from a rotating pattern. This exercises held requests and ports that alternate on consecutive cycles. Transfers of one, two and three bursts, plus a count with stray low bits, reach the single-burst end case, the multi-burst case and the bits 4:0 masking.

// File: rtl/aux_dma_pkg.sv
package aux_dma_pkg;

   localparam int HALF_W = 16;
   localparam int REG_W  = 32;

   typedef enum logic [2:0] {
      IX_MM_HI  = 3'd0,
      IX_MM_LO  = 3'd1,
      IX_AX_HI  = 3'd2,
      IX_AX_LO  = 3'd3,
      IX_CNT_HI = 3'd4,
      IX_CNT_LO = 3'd5,
      IX_CTRL   = 3'd6
   } reg_ix_e;

   localparam int CTRL_BUSY_BIT = 0;
   localparam int CTRL_PEND_BIT = 1;
   localparam int DIR_BIT       = 31;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_st_e;

endpackage

// File: rtl/aux_dma_regs.sv
module aux_dma_regs
   import aux_dma_pkg::*;
#(
   parameter int BURST_BYTES = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                h_wr,
   input  logic [2:0]          h_idx,
   input  logic [HALF_W-1:0]   h_wdata,
   output logic [HALF_W-1:0]   h_rdata,
   input  logic                burst_done,
   output logic [REG_W-1:0]    mm_base,
   output logic [REG_W-1:0]    ax_base,
   output logic                dir,
   output logic                busy,
   output logic                pending,
   output logic                last_burst
);

   localparam int BB_W = $clog2(BURST_BYTES);

   logic [REG_W-1:0] mm_q, ax_q, cnt_q;
   logic             busy_q, pend_q;
   logic             idle_wr;
   logic [REG_W-1:0] cnt_new;

   assign idle_wr    = h_wr && !busy_q;
   assign cnt_new    = {cnt_q[REG_W-1:HALF_W], h_wdata};
   assign last_burst = (cnt_q[DIR_BIT-1:BB_W] == {(DIR_BIT-BB_W){1'b0}} + 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mm_q   <= '0;
         ax_q   <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (idle_wr) begin
            unique case (h_idx)
               IX_MM_HI:  mm_q[REG_W-1:HALF_W]  <= h_wdata;
               IX_MM_LO:  mm_q[HALF_W-1:0]      <= h_wdata;
               IX_AX_HI:  ax_q[REG_W-1:HALF_W]  <= h_wdata;
               IX_AX_LO:  ax_q[HALF_W-1:0]      <= h_wdata;
               IX_CNT_HI: cnt_q[REG_W-1:HALF_W] <= h_wdata;
               IX_CNT_LO: begin
                  cnt_q[HALF_W-1:0] <= h_wdata;
                  if (cnt_new[DIR_BIT-1:BB_W] != '0) busy_q <= 1'b1;
               end
               default: ;
            endcase
         end
         if (h_wr && h_idx == IX_CTRL && h_wdata[CTRL_PEND_BIT])
            pend_q <= 1'b0;
         if (burst_done && busy_q) begin
            mm_q <= mm_q + REG_W'(BURST_BYTES);
            ax_q <= ax_q + REG_W'(BURST_BYTES);
            cnt_q[DIR_BIT-1:0] <= cnt_q[DIR_BIT-1:0] - DIR_BIT'(BURST_BYTES);
            if (last_burst) begin
               busy_q <= 1'b0;
               pend_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      h_rdata = '0;
      unique case (h_idx)
         IX_MM_HI:  h_rdata = mm_q[REG_W-1:HALF_W];
         IX_MM_LO:  h_rdata = mm_q[HALF_W-1:0];
         IX_AX_HI:  h_rdata = ax_q[REG_W-1:HALF_W];
         IX_AX_LO:  h_rdata = ax_q[HALF_W-1:0];
         IX_CNT_HI: h_rdata = cnt_q[REG_W-1:HALF_W];
         IX_CNT_LO: h_rdata = cnt_q[HALF_W-1:0];
         IX_CTRL: begin
            h_rdata[CTRL_BUSY_BIT] = busy_q;
            h_rdata[CTRL_PEND_BIT] = pend_q;
         end
         default: h_rdata = '0;
      endcase
   end

   assign mm_base = mm_q;
   assign ax_base = ax_q;
   assign dir     = cnt_q[DIR_BIT];
   assign busy    = busy_q;
   assign pending = pend_q;

endmodule

// File: rtl/aux_dma_seq.sv
module aux_dma_seq
   import aux_dma_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int BURST_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              last_burst,
   output logic              rd_req,
   output logic              wr_req,
   input  logic              rd_ack,
   input  logic              wr_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] data_q,
   output logic [REG_W-1:0]  byte_off,
   output logic              burst_done
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int WPB        = BURST_BYTES / WORD_BYTES;
   localparam int WCNT_W     = (WPB > 1) ? $clog2(WPB) : 1;

   seq_st_e           st_q;
   logic [WCNT_W-1:0] word_q;
   logic              last_word;

   assign last_word  = (word_q == WCNT_W'(WPB - 1));
   assign rd_req     = (st_q == ST_READ);
   assign wr_req     = (st_q == ST_WRITE);
   assign burst_done = (st_q == ST_WRITE) && wr_ack && last_word;
   assign byte_off   = REG_W'(word_q) * REG_W'(WORD_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         word_q <= '0;
         data_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               word_q <= '0;
               if (busy) st_q <= ST_READ;
            end
            ST_READ: begin
               if (rd_ack) begin
                  data_q <= rd_data;
                  st_q   <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (wr_ack) begin
                  if (last_word) begin
                     word_q <= '0;
                     st_q   <= last_burst ? ST_IDLE : ST_READ;
                  end else begin
                     word_q <= word_q + 1'b1;
                     st_q   <= ST_READ;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/aux_dma_port.sv
module aux_dma_port
   import aux_dma_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit SRC_DIR = 1'b0
) (
   input  logic              dir,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [REG_W-1:0]  base,
   input  logic [REG_W-1:0]  byte_off,
   input  logic [DATA_W-1:0] data_q,
   output logic              req,
   output logic              we,
   output logic [REG_W-1:0]  addr,
   output logic [DATA_W-1:0] wdata,
   input  logic              ack,
   input  logic [DATA_W-1:0] rdata,
   output logic              rd_ack,
   output logic              wr_ack,
   output logic [DATA_W-1:0] rd_val
);

   logic is_src;

   assign is_src = (dir == SRC_DIR);
   assign req    = is_src ? rd_req : wr_req;
   assign we     = !is_src && wr_req;
   assign addr   = base + byte_off;
   assign wdata  = data_q;
   assign rd_ack = is_src && ack;
   assign wr_ack = !is_src && ack;
   assign rd_val = rd_ack ? rdata : '0;

endmodule

// File: rtl/aux_blk_dma.sv
module aux_blk_dma
   import aux_dma_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int BURST_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr,
   input  logic [2:0]        h_idx,
   input  logic [15:0]       h_wdata,
   output logic [15:0]       h_rdata,
   output logic              irq,
   output logic              mm_req,
   output logic              mm_we,
   output logic [31:0]       mm_addr,
   output logic [DATA_W-1:0] mm_wdata,
   input  logic              mm_ack,
   input  logic [DATA_W-1:0] mm_rdata,
   output logic              ax_req,
   output logic              ax_we,
   output logic [31:0]       ax_addr,
   output logic [DATA_W-1:0] ax_wdata,
   input  logic              ax_ack,
   input  logic [DATA_W-1:0] ax_rdata
);

   localparam int NPORT = 2;

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (BURST_BYTES < DATA_W / 8 || (BURST_BYTES & (BURST_BYTES - 1)) != 0
       || (BURST_BYTES % (DATA_W / 8)) != 0) begin : g_bad_burst
      $error("BURST_BYTES must be a power of two holding whole words");
   end

   logic              busy, pending, dir, last_burst, burst_done;
   logic              rd_req, wr_req, rd_ack, wr_ack;
   logic [REG_W-1:0]  mm_base, ax_base, byte_off;
   logic [DATA_W-1:0] data_q, rd_data;

   logic [NPORT-1:0]             p_req, p_we, p_ack, p_rd_ack, p_wr_ack;
   logic [NPORT-1:0][REG_W-1:0]  p_base, p_addr;
   logic [NPORT-1:0][DATA_W-1:0] p_wdata, p_rdata, p_rd_val;

   aux_dma_regs #(.BURST_BYTES(BURST_BYTES)) u_regs (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_idx(h_idx),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .burst_done(burst_done),
      .mm_base(mm_base), .ax_base(ax_base), .dir(dir), .busy(busy),
      .pending(pending), .last_burst(last_burst)
   );

   aux_dma_seq #(.DATA_W(DATA_W), .BURST_BYTES(BURST_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .busy(busy), .last_burst(last_burst),
      .rd_req(rd_req), .wr_req(wr_req), .rd_ack(rd_ack), .wr_ack(wr_ack),
      .rd_data(rd_data), .data_q(data_q), .byte_off(byte_off),
      .burst_done(burst_done)
   );

   assign p_base[0]  = mm_base;
   assign p_base[1]  = ax_base;
   assign p_ack[0]   = mm_ack;
   assign p_ack[1]   = ax_ack;
   assign p_rdata[0] = mm_rdata;
   assign p_rdata[1] = ax_rdata;

   for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
      aux_dma_port #(.DATA_W(DATA_W), .SRC_DIR(gp[0])) u_port (
         .dir(dir), .rd_req(rd_req), .wr_req(wr_req),
         .base(p_base[gp]), .byte_off(byte_off), .data_q(data_q),
         .req(p_req[gp]), .we(p_we[gp]), .addr(p_addr[gp]),
         .wdata(p_wdata[gp]), .ack(p_ack[gp]), .rdata(p_rdata[gp]),
         .rd_ack(p_rd_ack[gp]), .wr_ack(p_wr_ack[gp]),
         .rd_val(p_rd_val[gp])
      );
   end

   assign rd_ack  = |p_rd_ack;
   assign wr_ack  = |p_wr_ack;
   assign rd_data = p_rd_val[0] | p_rd_val[1];

   assign mm_req   = p_req[0];
   assign mm_we    = p_we[0];
   assign mm_addr  = p_addr[0];
   assign mm_wdata = p_wdata[0];
   assign ax_req   = p_req[1];
   assign ax_we    = p_we[1];
   assign ax_addr  = p_addr[1];
   assign ax_wdata = p_wdata[1];
   assign irq      = pending;

endmodule

// File: rtl/aux_dma_chk.sv
module aux_dma_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              h_wr,
   input logic [2:0]        h_idx,
   input logic              busy,
   input logic              irq,
   input logic              mm_req,
   input logic              mm_we,
   input logic [31:0]       mm_addr,
   input logic [DATA_W-1:0] mm_wdata,
   input logic              mm_ack,
   input logic              ax_req,
   input logic              ax_we,
   input logic [31:0]       ax_addr,
   input logic [DATA_W-1:0] ax_wdata,
   input logic              ax_ack
);

   a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      !(mm_req && ax_req));

   a_r11_mm_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_req && !mm_ack) |=> (mm_req && $stable(mm_addr) && $stable(mm_we)
                               && $stable(mm_wdata)));

   a_r11_ax_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ax_req && !ax_ack) |=> (ax_req && $stable(ax_addr) && $stable(ax_we)
                               && $stable(ax_wdata)));

   a_r6_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $fell(busy));

   a_r3_start_by_host: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(h_wr) && $past(h_idx) == 3'd5));

   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !(mm_req || ax_req) || busy);

endmodule

bind aux_blk_dma aux_dma_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_idx(h_idx), .busy(busy),
   .irq(irq), .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr),
   .mm_wdata(mm_wdata), .mm_ack(mm_ack), .ax_req(ax_req), .ax_we(ax_we),
   .ax_addr(ax_addr), .ax_wdata(ax_wdata), .ax_ack(ax_ack)
);

// File: tb/test_aux_blk_dma.sv
module test_aux_blk_dma;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          h_wr = 1'b0;
   logic [2:0]    h_idx = '0;
   logic [15:0]   h_wdata = '0;
   logic [15:0]   h_rdata;
   logic          irq;
   logic          mm_req, mm_we, ax_req, ax_we;
   logic [31:0]   mm_addr, ax_addr;
   logic [DW-1:0] mm_wdata, ax_wdata;
   logic          mm_ack = 1'b0, ax_ack = 1'b0;
   logic [DW-1:0] mm_rdata = '0, ax_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [31:0] mm_mem [int];
   logic [31:0] ax_mem [int];
   typedef struct { bit aux; int addr; logic [31:0] data; } wr_t;
   wr_t exp_q[$];
   bit  src_aux = 1'b0;
   int  lat_seed = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aux_blk_dma i_aux_blk_dma (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_idx(h_idx),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .irq(irq),
      .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr),
      .mm_wdata(mm_wdata), .mm_ack(mm_ack), .mm_rdata(mm_rdata),
      .ax_req(ax_req), .ax_we(ax_we), .ax_addr(ax_addr),
      .ax_wdata(ax_wdata), .ax_ack(ax_ack), .ax_rdata(ax_rdata)
   );

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_rd(bit aux, int a);
      if (aux) return ax_mem.exists(a) ? ax_mem[a] : (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
      return mm_mem.exists(a) ? mm_mem[a] : (32'(a) * 32'h9E3779B1);
   endfunction

   // Memory responder and per-clock reference comparison of every handshake
   initial begin
      int cnt_m = 0, cnt_a = 0, lat_m = 1, lat_a = 1;
      forever begin
         @(negedge clk);
         mm_ack = 1'b0;
         ax_ack = 1'b0;
         if (mm_req) begin
            cnt_m++;
            if (cnt_m >= lat_m) begin
               cnt_m = 0;
               lat_seed++;
               lat_m = 1 + (lat_seed % 3);
               mm_ack = 1'b1;
               if (mm_we) begin
                  wr_t e;
                  if (exp_q.size() == 0) begin
                     chk(1'b0, "R8", "unexpected main write", mm_addr, 0);
                  end else begin
                     e = exp_q.pop_front();
                     chk(!e.aux, "R5", "write went to main", 1, 0);
                     chk(mm_addr == e.addr, "R4", "main write addr", mm_addr, e.addr);
                     chk(mm_wdata == e.data, "R4", "main write data", mm_wdata, e.data);
                  end
                  mm_mem[int'(mm_addr)] = mm_wdata;
               end else begin
                  chk(!src_aux, "R5", "main read while aux is source", 1, 0);
                  mm_rdata = mem_rd(1'b0, int'(mm_addr));
               end
            end
         end else cnt_m = 0;
         if (ax_req) begin
            cnt_a++;
            if (cnt_a >= lat_a) begin
               cnt_a = 0;
               lat_seed++;
               lat_a = 1 + ((lat_seed + 1) % 3);
               ax_ack = 1'b1;
               if (ax_we) begin
                  wr_t e;
                  if (exp_q.size() == 0) begin
                     chk(1'b0, "R8", "unexpected aux write", ax_addr, 0);
                  end else begin
                     e = exp_q.pop_front();
                     chk(e.aux, "R5", "write went to aux", 1, 0);
                     chk(ax_addr == e.addr, "R4", "aux write addr", ax_addr, e.addr);
                     chk(ax_wdata == e.data, "R4", "aux write data", ax_wdata, e.data);
                  end
                  ax_mem[int'(ax_addr)] = ax_wdata;
               end else begin
                  chk(src_aux, "R5", "aux read while main is source", 1, 0);
                  ax_rdata = mem_rd(1'b1, int'(ax_addr));
               end
            end
         end else cnt_a = 0;
      end
   end

   task automatic hwrite(int idx, logic [15:0] v);
      @(negedge clk);
      h_wr = 1'b1; h_idx = 3'(idx); h_wdata = v;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic hread(int idx, output logic [15:0] v);
      h_idx = 3'(idx);
      #1 v = h_rdata;
   endtask

   task automatic read32(int idx_hi, output logic [31:0] v);
      logic [15:0] hi, lo;
      hread(idx_hi, hi);
      hread(idx_hi + 1, lo);
      v = {hi, lo};
   endtask

   task automatic wait_idle(int limit);
      logic [15:0] s;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         hread(6, s);
         if (!s[0]) return;
      end
   endtask

   // Programs a transfer, fills the reference queue, starts it and checks the end state
   task automatic run_xfer(logic [31:0] ma, logic [31:0] aa, logic [31:0] cnt, string tag);
      logic [15:0] s;
      logic [31:0] v;
      int nb, words;
      nb = int'(cnt[30:5]);
      words = nb * 8;
      src_aux = cnt[31];
      for (int i = 0; i < words; i++) begin
         wr_t e;
         e.aux  = !cnt[31];
         e.addr = int'((cnt[31] ? ma : aa) + 32'(4 * i));
         e.data = mem_rd(cnt[31], int'((cnt[31] ? aa : ma) + 32'(4 * i)));
         exp_q.push_back(e);
      end
      hwrite(0, ma[31:16]); hwrite(1, ma[15:0]);
      hwrite(2, aa[31:16]); hwrite(3, aa[15:0]);
      hwrite(4, cnt[31:16]);
      hread(6, s);
      chk(s[0] == 1'b0, "R3", {tag, " busy after high half only"}, s[0], 0);
      hwrite(5, cnt[15:0]);
      hread(6, s);
      chk(s[0] == 1'b1, "R3", {tag, " busy after start"}, s[0], 1);
      wait_idle(4000);
      hread(6, s);
      chk(s == 16'h0002, "R6", {tag, " status at end"}, s, 2);
      chk(irq == 1'b1, "R6", {tag, " irq at end"}, irq, 1);
      chk(exp_q.size() == 0, "R4", {tag, " words left"}, exp_q.size(), 0);
      read32(0, v);
      chk(v == ma + 32'(32 * nb), "R7", {tag, " main addr end"}, v, ma + 32'(32 * nb));
      read32(2, v);
      chk(v == aa + 32'(32 * nb), "R7", {tag, " aux addr end"}, v, aa + 32'(32 * nb));
      read32(4, v);
      chk(v == {cnt[31], 26'd0, cnt[4:0]}, "R7", {tag, " count end"}, v, {cnt[31], 26'd0, cnt[4:0]});
   endtask

   initial begin
      logic [15:0] s;
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      hread(6, s);
      chk(s == 16'h0, "R1", "status after reset", s, 0);
      chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
      for (int i = 0; i < 6; i++) begin
         hread(i, s);
         chk(s == 16'h0, "R1", "reg after reset", s, 0);
      end

      // R2 readback while idle
      hwrite(0, 16'h1234); hwrite(1, 16'h5678);
      hwrite(2, 16'h9ABC); hwrite(3, 16'hDEF0);
      hwrite(4, 16'h0001);
      read32(0, v);
      chk(v == 32'h12345678, "R2", "main addr readback", v, 32'h12345678);
      read32(2, v);
      chk(v == 32'h9ABCDEF0, "R2", "aux addr readback", v, 32'h9ABCDEF0);
      hread(4, s);
      chk(s == 16'h0001, "R2", "count high readback", s, 1);
      hread(6, s);
      chk(s[0] == 1'b0, "R3", "count high alone does not start", s[0], 0);
      hwrite(4, 16'h0000);

      // R4 R5 single burst main to aux
      run_xfer(32'h0000_1000, 32'h0000_0000, 32'h0000_0020, "one burst m2a");

      // R9 pending clear rules
      hwrite(6, 16'h0001);
      hread(6, s);
      chk(s == 16'h0002, "R9", "write without bit1 keeps pending", s, 2);
      hwrite(6, 16'h0002);
      hread(6, s);
      chk(s == 16'h0000, "R9", "write with bit1 clears pending", s, 0);
      chk(irq == 1'b0, "R6", "irq follows pending", irq, 0);

      // R5 R7 three bursts aux to main
      run_xfer(32'h0002_0040, 32'h0000_0200, 32'h8000_0060, "three bursts a2m");
      hwrite(6, 16'h0002);

      // R4 stray low count bits
      run_xfer(32'h0000_3000, 32'h0000_0800, 32'h0000_0028, "low bits m2a");
      hwrite(6, 16'h0002);

      // R8 writes while busy are ignored
      begin
         int words;
         src_aux = 1'b0;
         words = 16;
         for (int i = 0; i < words; i++) begin
            wr_t e;
            e.aux = 1'b1;
            e.addr = 32'h0000_4000 + 4 * i;
            e.data = mem_rd(1'b0, 32'h0000_5000 + 4 * i);
            exp_q.push_back(e);
         end
         hwrite(0, 16'h0000); hwrite(1, 16'h5000);
         hwrite(2, 16'h0000); hwrite(3, 16'h4000);
         hwrite(4, 16'h0000); hwrite(5, 16'h0040);
         hwrite(1, 16'hFFE0);
         hwrite(3, 16'hEEE0);
         hwrite(4, 16'h0007);
         hwrite(5, 16'h0400);
         wait_idle(4000);
         repeat (20) @(negedge clk);
         hread(6, s);
         chk(s[0] == 1'b0, "R8", "no restart from busy write", s[0], 0);
         chk(exp_q.size() == 0, "R8", "words left", exp_q.size(), 0);
         read32(0, v);
         chk(v == 32'h0000_5040, "R8", "main addr unchanged by busy write", v, 32'h5040);
         read32(2, v);
         chk(v == 32'h0000_4040, "R8", "aux addr unchanged by busy write", v, 32'h4040);
         read32(4, v);
         chk(v == 32'h0000_0000, "R8", "count unchanged by busy write", v, 0);
         hwrite(6, 16'h0002);
      end

      // R10 zero bursts
      hwrite(4, 16'h0000);
      hwrite(5, 16'h001F);
      hread(6, s);
      chk(s == 16'h0000, "R10", "zero bursts no start", s, 0);
      repeat (5) @(negedge clk);
      chk(!mm_req && !ax_req, "R10", "no memory traffic", {mm_req, ax_req}, 0);
      hread(5, s);
      chk(s == 16'h001F, "R10", "count stored", s, 16'h1F);
      chk(irq == 1'b0, "R10", "irq unchanged", irq, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule